// File: doc/BRIEF.md
# Packet-Switched Stream Header Sender

This block is a stream source that shares a single 32-bit output channel among several logical destinations by packet switching. One run is started by a pulse and covers a chosen number of rounds. In each round the block visits every destination in table order. For each destination it sends one header word, then a fixed-length burst of data words. The last data word of each burst carries the end-of-packet flag. A splitter further along the path reads each header and sends the burst that follows it to the right consumer.

The header is built in hardware from two inputs. The destination ID comes from a table input, because the IDs can change from one build of the downstream fabric to the next. The packet type is a small input that is sampled when the run starts. The header also carries an all-ones source row and column, which mark the packet as coming from outside the array, and a top bit that gives the whole word odd parity. Data words come either from a counter pattern or from a per-destination data input. The output follows valid/ready backpressure, and a done flag reports the end of the run.

Top module: `pkt_hdr_sender`

## Requirements
- R1: Header bits [4:0] equal the ID table entry of the destination being served. Entry i occupies `dest_ids[5*i +: 5]`.
- R2: Header bits [14:12] equal the packet type sampled at the accepted start. Header bits [11:5], bit 15 and bits [30:28] are zero.
- R3: Header bits [20:16] (source row) and bits [27:21] (source column) are all ones.
- R4: Header bit 31 is 1 when the XOR of bits [30:0] is 0, and 0 otherwise, so every header has an odd number of ones.
- R5: Each packet is one header beat with `m_tlast` low, followed by `PKT_LEN` data beats (default 8). `m_tlast` is high only on the last data beat.
- R6: A run sends destinations 0 to NUM_DEST-1 in that order once per round, for exactly the sampled number of rounds. That is iterations × NUM_DEST × (PKT_LEN+1) beats in total.
- R7: The data word at data-beat index k, counting from 0, depends on `data_mode`. With `data_mode`=0 it is `{8-bit destination index, low 8 bits of the round number, 16-bit k}`. With `data_mode`=1 it is `src_data[32*d +: 32]` for destination d.
- R8: `m_tkeep` is all ones on every beat.
- R9: When `m_tvalid` is high and `m_tready` is low, the next cycle still has `m_tvalid` high, with `m_tdata` and `m_tlast` unchanged.
- R10: A start pulse is accepted only while `busy` is low. It samples `iter_count` and `pkt_type`, and `busy` rises on the next cycle. A start pulse, or a change to `iter_count` or `pkt_type`, while busy has no effect on the run.
- R11: `done` rises in the cycle after the last handshake, with `busy` low. It stays high until the next accepted start. A start with `iter_count`=0 raises `done` on the next cycle and sends no beats.
- R12: During and right after reset, `m_tvalid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run start pulse |
| iter_count | input | ITER_W | Number of rounds to send |
| pkt_type | input | 3 | Packet type placed in each header |
| data_mode | input | 1 | 0: counter pattern, 1: per-destination data input |
| dest_ids | input | 5*NUM_DEST | Destination ID table |
| src_data | input | 32*NUM_DEST | Per-destination data words |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 32 | Output beat data |
| m_tlast | output | 1 | Last beat of a packet |
| m_tkeep | output | 4 | Byte enables |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |

## Verification
The hardest case to reach from the ports is a stall at a boundary. This covers a held header beat, a held final data beat, and a stall that falls on the wrap from the last destination of one round to the first destination of the next. It also covers start and input changes that arrive in the middle of a run. The stimulus drives `m_tready` from a set of irregular 8-cycle masks, one per vector, so stalls land on many different beat positions across several rounds. Some vectors pulse `start` and change `iter_count` and `pkt_type` while the run is busy. A reference model in the bench follows each accepted beat and rebuilds every header field and the parity by counting bits.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 5;
  localparam int TYPE_W = 3;
  localparam int KEEP_W = WORD_W / 8;

  // Bit positions fixed by the downstream header decoder
  localparam int ID_LSB   = 0;
  localparam int TYPE_LSB = 12;
  localparam int ROW_LSB  = 16;
  localparam int ROW_W    = 5;
  localparam int COL_LSB  = 21;
  localparam int COL_W    = 7;
  localparam int PAR_BIT  = 31;

  // Top bit chosen so the full word carries an odd count of ones
  function automatic logic odd_par_bit(input logic [WORD_W-2:0] body);
    return ~(^body);
  endfunction

  function automatic logic [WORD_W-1:0] make_header(
      input logic [ID_W-1:0]   id,
      input logic [TYPE_W-1:0] ptype);
    logic [WORD_W-1:0] h;
    h = '0;
    h[ID_LSB +: ID_W]     = id;
    h[TYPE_LSB +: TYPE_W] = ptype;
    h[ROW_LSB +: ROW_W]   = '1;
    h[COL_LSB +: COL_W]   = '1;
    h[PAR_BIT]            = odd_par_bit(h[WORD_W-2:0]);
    return h;
  endfunction

  // Counter pattern: {dest index, round low byte, beat index}
  function automatic logic [WORD_W-1:0] count_word(
      input logic [31:0] dest,
      input logic [31:0] iter,
      input logic [31:0] beat);
    return ((dest & 32'hFF) << 24) | ((iter & 32'hFF) << 16) | (beat & 32'hFFFF);
  endfunction
endpackage

// File: rtl/pkt_seq.sv
module pkt_seq #(
  parameter int NUM_DEST = 4,
  parameter int PKT_LEN  = 8,
  parameter int ITER_W   = 16,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int BEAT_W  = $clog2(PKT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] iter_count,
  input  logic              ready,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              hdr_beat,
  output logic              last_beat,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [DEST_W-1:0] dest_idx,
  output logic [ITER_W-1:0] iter_idx
);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(PKT_LEN);
  localparam logic [DEST_W-1:0] DEST_LAST = DEST_W'(NUM_DEST - 1);

  logic [ITER_W-1:0] iter_lim;
  logic              fire;
  logic              dest_wrap;
  logic              round_end;

  assign accept    = start && !busy;
  assign fire      = busy && ready;
  assign hdr_beat  = busy && (beat_idx == '0);
  assign last_beat = busy && (beat_idx == BEAT_LAST);
  assign dest_wrap = (dest_idx == DEST_LAST);
  assign round_end = (iter_idx == iter_lim - ITER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      beat_idx <= '0;
      dest_idx <= '0;
      iter_idx <= '0;
      iter_lim <= '0;
    end else if (accept) begin
      busy     <= (iter_count != '0);
      done     <= (iter_count == '0);
      iter_lim <= iter_count;
      beat_idx <= '0;
      dest_idx <= '0;
      iter_idx <= '0;
    end else if (fire) begin
      if (last_beat) begin
        beat_idx <= '0;
        if (dest_wrap) begin
          dest_idx <= '0;
          if (round_end) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            iter_idx <= iter_idx + ITER_W'(1);
          end
        end else begin
          dest_idx <= dest_idx + DEST_W'(1);
        end
      end else begin
        beat_idx <= beat_idx + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_hdr_gen.sv
module pkt_hdr_gen
  import pkt_hdr_pkg::*;
#(
  parameter int NUM_DEST = 4,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic [ID_W*NUM_DEST-1:0] dest_ids,
  input  logic [DEST_W-1:0]        dest_idx,
  input  logic [TYPE_W-1:0]        ptype,
  output logic [WORD_W-1:0]        header
);
  logic [ID_W-1:0] id_tab [NUM_DEST];

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_tab
    assign id_tab[g] = dest_ids[g*ID_W +: ID_W];
  end

  assign header = make_header(id_tab[dest_idx], ptype);
endmodule

// File: rtl/pkt_data_gen.sv
module pkt_data_gen
  import pkt_hdr_pkg::*;
#(
  parameter int NUM_DEST = 4,
  parameter int PKT_LEN  = 8,
  parameter int ITER_W   = 16,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int BEAT_W  = $clog2(PKT_LEN + 1)
) (
  input  logic                       data_mode,
  input  logic [WORD_W*NUM_DEST-1:0] src_data,
  input  logic [DEST_W-1:0]          dest_idx,
  input  logic [ITER_W-1:0]          iter_idx,
  input  logic [BEAT_W-1:0]          beat_idx,
  output logic [WORD_W-1:0]          data
);
  logic [WORD_W-1:0] src_tab [NUM_DEST];
  logic [31:0]       data_k;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_src
    assign src_tab[g] = src_data[g*WORD_W +: WORD_W];
  end

  // Data beats sit at beat_idx 1..PKT_LEN; k counts from zero
  assign data_k = 32'(beat_idx) - 32'd1;

  always_comb begin
    if (data_mode) data = src_tab[dest_idx];
    else           data = count_word(32'(dest_idx), 32'(iter_idx), data_k);
  end
endmodule

// File: rtl/pkt_hdr_sender.sv
module pkt_hdr_sender
  import pkt_hdr_pkg::*;
#(
  parameter int NUM_DEST = 4,
  parameter int PKT_LEN  = 8,
  parameter int ITER_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ITER_W-1:0]          iter_count,
  input  logic [TYPE_W-1:0]          pkt_type,
  input  logic                       data_mode,
  input  logic [ID_W*NUM_DEST-1:0]   dest_ids,
  input  logic [WORD_W*NUM_DEST-1:0] src_data,
  output logic                       m_tvalid,
  input  logic                       m_tready,
  output logic [WORD_W-1:0]          m_tdata,
  output logic                       m_tlast,
  output logic [KEEP_W-1:0]          m_tkeep,
  output logic                       busy,
  output logic                       done
);
  localparam int DEST_W = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1;
  localparam int BEAT_W = $clog2(PKT_LEN + 1);

  logic              accept;
  logic              hdr_beat;
  logic              last_beat;
  logic [BEAT_W-1:0] beat_idx;
  logic [DEST_W-1:0] dest_idx;
  logic [ITER_W-1:0] iter_idx;
  logic [TYPE_W-1:0] type_q;
  logic [WORD_W-1:0] header;
  logic [WORD_W-1:0] data;

  pkt_seq #(.NUM_DEST(NUM_DEST), .PKT_LEN(PKT_LEN), .ITER_W(ITER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .ready(m_tready), .busy(busy), .done(done), .accept(accept),
    .hdr_beat(hdr_beat), .last_beat(last_beat), .beat_idx(beat_idx),
    .dest_idx(dest_idx), .iter_idx(iter_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      type_q <= '0;
    else if (accept) type_q <= pkt_type;
  end

  pkt_hdr_gen #(.NUM_DEST(NUM_DEST)) u_hdr (
    .dest_ids(dest_ids), .dest_idx(dest_idx), .ptype(type_q), .header(header)
  );

  pkt_data_gen #(.NUM_DEST(NUM_DEST), .PKT_LEN(PKT_LEN), .ITER_W(ITER_W)) u_data (
    .data_mode(data_mode), .src_data(src_data), .dest_idx(dest_idx),
    .iter_idx(iter_idx), .beat_idx(beat_idx), .data(data)
  );

  assign m_tvalid = busy;
  assign m_tdata  = hdr_beat ? header : data;
  assign m_tlast  = last_beat;
  assign m_tkeep  = '1;
endmodule

// File: rtl/pkt_hdr_sender_chk.sv
module pkt_hdr_sender_chk #(
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ITER_W-1:0] iter_count,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [31:0]       m_tdata,
  input logic              m_tlast,
  input logic              busy,
  input logic              done,
  input logic              hdr_beat
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R4
  hdr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_beat |-> (^m_tdata) == 1'b1);

  // R3
  hdr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_beat |-> (m_tdata[27:16] == 12'hFFF));

  // R5
  hdr_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_beat |-> !m_tlast);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !m_tvalid);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && iter_count != '0) |=> busy);
endmodule

bind pkt_hdr_sender pkt_hdr_sender_chk #(.ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tlast(m_tlast), .busy(busy), .done(done), .hdr_beat(hdr_beat)
);

// File: tb/pkt_hdr_sender_tb.sv
`timescale 1ns/1ps
module pkt_hdr_sender_tb;
  localparam int NUM_DEST = 4;
  localparam int PKT_LEN  = 8;
  localparam int ITER_W   = 16;

  // {perturb, iters, type, mode, ready mask}
  localparam logic [39:0] VEC [0:4] = '{
    {8'd0, 8'd1, 8'd0, 8'd0, 8'hFF},
    {8'd0, 8'd2, 8'd5, 8'd0, 8'b10110110},
    {8'd1, 8'd3, 8'd7, 8'd1, 8'b01011011},
    {8'd0, 8'd1, 8'd3, 8'd1, 8'b00010001},
    {8'd1, 8'd2, 8'd6, 8'd0, 8'b11001101}
  };

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start = 1'b0;
  logic [ITER_W-1:0]        iter_count = '0;
  logic [2:0]               pkt_type = '0;
  logic                     data_mode = 1'b0;
  logic [5*NUM_DEST-1:0]    dest_ids;
  logic [32*NUM_DEST-1:0]   src_data;
  logic                     m_tvalid;
  logic                     m_tready = 1'b0;
  logic [31:0]              m_tdata;
  logic                     m_tlast;
  logic [3:0]               m_tkeep;
  logic                     busy;
  logic                     done;
  logic [4:0]               ids [NUM_DEST];
  int                       checks = 0;
  int                       fails = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_DEST; i++) begin
      dest_ids[i*5 +: 5]  = ids[i];
      src_data[i*32 +: 32] = 32'hC0DE_0000 + 32'(i) * 32'h0111;
    end
  end

  pkt_hdr_sender #(.NUM_DEST(NUM_DEST), .PKT_LEN(PKT_LEN), .ITER_W(ITER_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .pkt_type(pkt_type), .data_mode(data_mode), .dest_ids(dest_ids),
    .src_data(src_data), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tkeep(m_tkeep),
    .busy(busy), .done(done)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [31:0] w);
    int n = 0;
    for (int b = 0; b < 32; b++) n += int'(w[b]);
    return n;
  endfunction

  task automatic run_case(input int iters, input logic [2:0] ptype, input logic mode,
                          input logic [7:0] mask, input logic perturb);
    int  e_beat = 0, e_dest = 0, e_iter = 0, beats = 0, cyc = 0, last_hs = -10;
    bit  seen_done = 0, prev_stall = 0, prev_last = 0;
    logic [31:0] prev_data = '0, exp_w;
    @(negedge clk);
    iter_count = ITER_W'(iters); pkt_type = ptype; data_mode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R10 busy after start", {30'd0, busy, done}, 32'h2);
    while (!seen_done && cyc < 4000) begin
      if (prev_stall)
        check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R9 stall hold",
              m_tdata, prev_data);
      if (perturb && cyc == 3) begin
        start = 1'b1; iter_count = ITER_W'(iters + 5); pkt_type = ~ptype;
      end
      if (perturb && cyc == 4) start = 1'b0;
      m_tready = mask[cyc % 8];
      if (m_tvalid && m_tready) begin
        check(m_tkeep == 4'hF, "R8 keep", 32'(m_tkeep), 32'hF);
        if (e_beat == 0) begin
          check(m_tdata[4:0] == ids[e_dest], "R1 id", 32'(m_tdata[4:0]), 32'(ids[e_dest]));
          check(m_tdata[14:12] == ptype, "R2 type", 32'(m_tdata[14:12]), 32'(ptype));
          check(m_tdata[11:5] == 0 && !m_tdata[15] && m_tdata[30:28] == 0, "R2 zero",
                m_tdata, 32'h0);
          check(m_tdata[20:16] == 5'h1F && m_tdata[27:21] == 7'h7F, "R3 row col",
                32'(m_tdata[27:16]), 32'hFFF);
          check(ones(m_tdata) % 2 == 1, "R4 parity", 32'(ones(m_tdata)), 32'h1);
          check(!m_tlast, "R5 header tlast", 32'(m_tlast), 32'h0);
        end else begin
          if (mode) exp_w = 32'hC0DE_0000 + 32'(e_dest) * 32'h0111;
          else      exp_w = {8'(e_dest), 8'(e_iter), 16'(e_beat - 1)};
          check(m_tdata == exp_w, "R7 data", m_tdata, exp_w);
          check(m_tlast == (e_beat == PKT_LEN), "R5 tlast", 32'(m_tlast),
                32'(e_beat == PKT_LEN));
        end
        beats++; last_hs = cyc;
        if (e_beat == PKT_LEN) begin
          e_beat = 0;
          if (e_dest == NUM_DEST - 1) begin e_dest = 0; e_iter++; end
          else e_dest++;
        end else e_beat++;
      end
      prev_stall = m_tvalid && !m_tready;
      prev_data = m_tdata; prev_last = m_tlast;
      @(negedge clk);
      cyc++;
      if (done) begin
        seen_done = 1;
        check(cyc == last_hs + 1 && !m_tvalid && !busy, "R11 done timing", 32'(cyc),
              32'(last_hs + 1));
      end
    end
    check(seen_done, "R11 done seen", 32'(seen_done), 32'h1);
    check(beats == iters * NUM_DEST * (PKT_LEN + 1) && e_iter == iters, "R6 beat count",
          32'(beats), 32'(iters * NUM_DEST * (PKT_LEN + 1)));
    if (perturb) check(e_iter == iters, "R10 ignored mid-run", 32'(e_iter), 32'(iters));
    m_tready = 1'b0;
    iter_count = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ids[0] = 5'd3; ids[1] = 5'd17; ids[2] = 5'd30; ids[3] = 5'd9;
    m_tready = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!m_tvalid && !busy && !done, "R12 in reset", {29'd0, m_tvalid, busy, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!m_tvalid && !busy && !done, "R12 after reset", {29'd0, m_tvalid, busy, done}, 32'h0);

    // R11 zero-round start
    iter_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !busy && !m_tvalid, "R11 zero rounds", {29'd0, m_tvalid, busy, done}, 32'h1);
    repeat (3) @(negedge clk);
    check(!m_tvalid, "R11 zero rounds no beats", 32'(m_tvalid), 32'h0);
    m_tready = 1'b0;

    for (int v = 0; v < 5; v++)
      run_case(int'(VEC[v][31:24]), VEC[v][18:16], VEC[v][8], VEC[v][7:0], VEC[v][32]);

    // R1 table rewritten between runs
    ids[0] = 5'd31; ids[1] = 5'd0; ids[2] = 5'd22; ids[3] = 5'd5;
    run_case(1, 3'd2, 1'b0, 8'b01101111, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule